// File: doc/BRIEF.md
# Motion-Compensation Reference Pixel Cache

This block keeps recently used reference-frame pixels on chip, so that the overlapping reference areas of neighbouring prediction units are not read again from external memory. A dispatch stage hands it a window: a frame number, a top-left pixel position and a size in pixels. The cache splits the window into 2-D tiles of `TW`x`TH` pixels. It looks up each tile in a two-way set-associative tag store, and for every absent tile it issues one line read on a memory bus.

Responses on that bus can arrive after an arbitrary delay and in any order. Each response carries back the identifier of its request and fills the line slot that the identifier names. Tiles of the window being assembled are locked against eviction. Once every tile of the window is resident and no read is outstanding, the cache raises a ready flag. The fetch stage can then read single pixels by absolute coordinate, with one cycle of latency.

Hit and miss counters are brought out so that the reuse of lines can be observed.

Top module: `mcc_ref_cache`

## Requirements
- R1: A window at (x, y) of size w by h covers tile columns floor(x/TW) through floor((x+w-1)/TW) and tile rows floor(y/TH) through floor((y+h-1)/TH). Each covered tile is looked up exactly once, adding one to either `hit_count` or `miss_count`.
- R2: Every miss produces exactly one bus request carrying the tile's frame and tile coordinates. While `mem_req_ready` is low, the request and its fields hold steady.
- R3: `win_ready` rises only after the responses for all of the window's misses have been taken in. No bus request is issued while `win_ready` is high.
- R4: A pixel read presented with `rd_valid` while `win_ready` is high returns `rd_data_valid` on the next cycle. The byte returned sits at slot k = (y mod TH)*TW + (x mod TW) of its tile, where slot k occupies bits [8k+7:8k] of the line.
- R5: A tile that is already resident from an earlier window counts as a hit and causes no bus traffic.
- R6: A tile maps to set {ty[0], tx[1:0]}, which has two ways. On a miss the first invalid way is filled. If both ways are valid, the least recently used way is replaced.
- R7: A line touched by the window being assembled is never chosen for replacement within that window.
- R8: Responses may return out of order. Each one is matched to its line only by the identifier echoed from its request.
- R9: After reset, no line is valid, both counters read zero, `req_accept` is high and `win_ready` is low.
- R10: A new window is taken only while the cache is idle or ready. Both `req_accept` and `win_ready` are low on the cycle after a window is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Window request strobe |
| req_frame | input | 2 | Reference frame number |
| req_x | input | 8 | Window left pixel column |
| req_y | input | 8 | Window top pixel row |
| req_w | input | 5 | Window width in pixels (1 or more) |
| req_h | input | 5 | Window height in pixels (1 or more) |
| req_accept | output | 1 | Cache can take a new window |
| win_ready | output | 1 | Whole window resident |
| rd_valid | input | 1 | Pixel read strobe |
| rd_x | input | 8 | Pixel column to read |
| rd_y | input | 8 | Pixel row to read |
| rd_data_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Pixel value |
| mem_req_valid | output | 1 | Line read request |
| mem_req_ready | input | 1 | Bus accepts request |
| mem_req_id | output | 4 | Request identifier |
| mem_req_frame | output | 2 | Frame of requested tile |
| mem_req_tx | output | 6 | Tile column of requested tile |
| mem_req_ty | output | 7 | Tile row of requested tile |
| mem_rsp_valid | input | 1 | Line data returning |
| mem_rsp_id | input | 4 | Identifier of returning line |
| mem_rsp_data | input | 64 | Line pixels, slot k at bits [8k+7:8k] |
| hit_count | output | 16 | Tile lookups that hit |
| miss_count | output | 16 | Tile lookups that missed |

## Verification
The assertions take for granted that a window spans no more than four tile columns and four tile rows, and that its width and height are at least one pixel. They also assume that the bus only returns identifiers that are still outstanding. The stimulus stays within these limits: it derives each random width and height from the window's offset inside its tile, so that the tile span never exceeds four. The bench responder answers only requests it has recorded, after a random delay and in random order. Pixel reads are issued only after `win_ready` and only inside the current window.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WALK,
    ST_BUSREQ,
    ST_DRAIN,
    ST_READY
  } walk_st_e;

  // first tile index touched by a pixel span
  function automatic int unsigned tile_first(input int unsigned pos, input int unsigned lg);
    return pos >> lg;
  endfunction

  // last tile index touched by a pixel span of len >= 1
  function automatic int unsigned tile_last(input int unsigned pos, input int unsigned len,
                                            input int unsigned lg);
    return (pos + len - 1) >> lg;
  endfunction

  // byte slot of a pixel inside its tile, row-major
  function automatic int unsigned byte_slot(input int unsigned px, input int unsigned py,
                                            input int unsigned twl, input int unsigned thl);
    return ((py & ((32'd1 << thl) - 1)) << twl) | (px & ((32'd1 << twl) - 1));
  endfunction

  // set index: low column bits, then low row bits above them
  function automatic int unsigned set_index(input int unsigned tx, input int unsigned ty,
                                            input int unsigned xb, input int unsigned yb);
    return ((ty & ((32'd1 << yb) - 1)) << xb) | (tx & ((32'd1 << xb) - 1));
  endfunction

endpackage

// File: rtl/mcc_tags.sv
module mcc_tags #(
  parameter int FW   = 2,
  parameter int TXW  = 6,
  parameter int TYW  = 7,
  parameter int SETS = 8,
  parameter int XB   = 2,
  localparam int SIB  = $clog2(SETS),
  localparam int IDW  = SIB + 1,
  localparam int LINES = SETS * 2,
  localparam int YB   = SIB - XB,
  localparam int TAGW = FW + TXW + TYW
) (
  input  logic           clk,
  input  logic           rst_n,
  // walker lookup port
  input  logic [FW-1:0]  a_frame,
  input  logic [TXW-1:0] a_tx,
  input  logic [TYW-1:0] a_ty,
  output logic           a_hit,
  output logic           a_hit_way,
  output logic           a_victim_way,
  output logic [SIB-1:0] a_set,
  // update on the looked-up set
  input  logic           upd_en,
  input  logic           upd_alloc,
  input  logic           upd_way,
  input  logic           pin_clear,
  // refill completion
  input  logic           rsp_en,
  input  logic [IDW-1:0] rsp_id,
  // pixel read lookup port
  input  logic [FW-1:0]  b_frame,
  input  logic [TXW-1:0] b_tx,
  input  logic [TYW-1:0] b_ty,
  output logic           b_hit,
  output logic [IDW-1:0] b_id,
  output logic           pend_any
);

  logic [TAGW-1:0]  tag_q [LINES];
  logic [LINES-1:0] valid_q, pend_q, pin_q;
  logic [SETS-1:0]  lru_q;

  logic [TAGW-1:0]  a_key, b_key;
  logic [SIB-1:0]   b_set;
  logic [1:0]       hit_a, hit_b;
  logic [IDW-1:0]   upd_idx;

  assign a_set = SIB'(mcc_pkg::set_index(a_tx, a_ty, XB, YB));
  assign b_set = SIB'(mcc_pkg::set_index(b_tx, b_ty, XB, YB));
  assign a_key = {a_frame, a_tx, a_ty};
  assign b_key = {b_frame, b_tx, b_ty};

  for (genvar g = 0; g < 2; g++) begin : g_way
    logic [IDW-1:0] ia, ib;
    assign ia       = {a_set, 1'(g)};
    assign ib       = {b_set, 1'(g)};
    assign hit_a[g] = valid_q[ia] && (tag_q[ia] == a_key);
    assign hit_b[g] = valid_q[ib] && (tag_q[ib] == b_key);
  end

  assign a_hit     = |hit_a;
  assign a_hit_way = hit_a[1];
  assign b_hit     = |hit_b;
  assign b_id      = {b_set, hit_b[1]};
  assign pend_any  = |pend_q;
  assign upd_idx   = {a_set, upd_way};

  // victim: invalid way first, then LRU unless it is locked
  always_comb begin
    logic lw;
    lw = lru_q[a_set];
    a_victim_way = 1'b0;
    if (!valid_q[{a_set, 1'b0}])      a_victim_way = 1'b0;
    else if (!valid_q[{a_set, 1'b1}]) a_victim_way = 1'b1;
    else if (pin_q[{a_set, lw}])      a_victim_way = ~lw;
    else                              a_victim_way = lw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      pend_q  <= '0;
      pin_q   <= '0;
      lru_q   <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else begin
      if (pin_clear) pin_q <= '0;
      if (rsp_en)    pend_q[rsp_id] <= 1'b0;
      if (upd_en) begin
        pin_q[upd_idx] <= 1'b1;
        lru_q[a_set]   <= ~upd_way;
        if (upd_alloc) begin
          tag_q[upd_idx]   <= a_key;
          valid_q[upd_idx] <= 1'b1;
          pend_q[upd_idx]  <= 1'b1;
        end
      end
    end
  end

  AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_alloc |-> !pin_q[upd_idx]);  // R7
  AST_RSP_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_en |-> pend_q[rsp_id]);  // R8
  AST_HIT_SINGLE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> !(hit_a[0] && hit_a[1]));  // R6

endmodule

// File: rtl/mcc_lines.sv
module mcc_lines #(
  parameter int LINES = 16,
  parameter int PW    = 8,
  parameter int TW    = 4,
  parameter int TH    = 2,
  localparam int IDW   = $clog2(LINES),
  localparam int NPIX  = TW * TH,
  localparam int SLW   = $clog2(NPIX),
  localparam int LINEW = NPIX * PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDW-1:0]   wr_id,
  input  logic [LINEW-1:0] wr_data,
  input  logic             rd_en,
  input  logic [IDW-1:0]   rd_id,
  input  logic [SLW-1:0]   rd_slot,
  output logic             rd_valid_o,
  output logic [PW-1:0]    rd_data_o
);

  logic [NPIX-1:0][PW-1:0] line_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) line_q[wr_id] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en;
      if (rd_en) rd_data_o <= line_q[rd_id][rd_slot];
    end
  end

endmodule

// File: rtl/mcc_walker.sv
module mcc_walker import mcc_pkg::*; #(
  parameter int CW   = 8,
  parameter int SW   = 5,
  parameter int FW   = 2,
  parameter int TWL  = 2,
  parameter int THL  = 1,
  parameter int MAXT = 4,
  parameter int CNTW = 16,
  parameter int SIB  = 3,
  localparam int TXW = CW - TWL,
  localparam int TYW = CW - THL,
  localparam int IDW = SIB + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [FW-1:0]   req_frame,
  input  logic [CW-1:0]   req_x,
  input  logic [CW-1:0]   req_y,
  input  logic [SW-1:0]   req_w,
  input  logic [SW-1:0]   req_h,
  output logic            req_accept,
  output logic            win_ready,
  output logic [FW-1:0]   cur_frame,
  output logic [TXW-1:0]  cur_tx,
  output logic [TYW-1:0]  cur_ty,
  input  logic            a_hit,
  input  logic            a_hit_way,
  input  logic            a_victim_way,
  input  logic [SIB-1:0]  a_set,
  input  logic            pend_any,
  output logic            upd_en,
  output logic            upd_alloc,
  output logic            upd_way,
  output logic            pin_clear,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [IDW-1:0]  mem_req_id,
  output logic [CNTW-1:0] hit_count,
  output logic [CNTW-1:0] miss_count
);

  walk_st_e       st_q;
  logic [TXW-1:0] tx0_q, tx1_q;
  logic [TYW-1:0] ty1_q;
  logic [IDW-1:0] id_q;
  logic           take, row_end, last_tile, step;
  logic [TXW-1:0] req_tx0, req_tx1;
  logic [TYW-1:0] req_ty0, req_ty1;

  assign req_tx0 = TXW'(tile_first(req_x, TWL));
  assign req_tx1 = TXW'(tile_last(req_x, req_w, TWL));
  assign req_ty0 = TYW'(tile_first(req_y, THL));
  assign req_ty1 = TYW'(tile_last(req_y, req_h, THL));

  assign req_accept    = (st_q == ST_IDLE) || (st_q == ST_READY);
  assign win_ready     = (st_q == ST_READY);
  assign take          = req_valid && req_accept;
  assign pin_clear     = take;
  assign upd_en        = (st_q == ST_WALK);
  assign upd_alloc     = !a_hit;
  assign upd_way       = a_hit ? a_hit_way : a_victim_way;
  assign mem_req_valid = (st_q == ST_BUSREQ);
  assign mem_req_id    = id_q;
  assign row_end       = (cur_tx == tx1_q);
  assign last_tile     = row_end && (cur_ty == ty1_q);
  assign step          = ((st_q == ST_WALK) && a_hit) || ((st_q == ST_BUSREQ) && mem_req_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cur_frame  <= '0;
      cur_tx     <= '0;
      cur_ty     <= '0;
      tx0_q      <= '0;
      tx1_q      <= '0;
      ty1_q      <= '0;
      id_q       <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      case (st_q)
        ST_IDLE, ST_READY: begin
          if (take) begin
            cur_frame <= req_frame;
            cur_tx    <= req_tx0;
            tx0_q     <= req_tx0;
            tx1_q     <= req_tx1;
            cur_ty    <= req_ty0;
            ty1_q     <= req_ty1;
            st_q      <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (a_hit) hit_count <= hit_count + 1'b1;
          else begin
            miss_count <= miss_count + 1'b1;
            id_q       <= {a_set, a_victim_way};
            st_q       <= ST_BUSREQ;
          end
        end
        ST_DRAIN: if (!pend_any) st_q <= ST_READY;
        default: ;
      endcase
      if (step) begin
        if (last_tile) st_q <= ST_DRAIN;
        else begin
          st_q <= ST_WALK;
          if (row_end) begin
            cur_tx <= tx0_q;
            cur_ty <= cur_ty + 1'b1;
          end else begin
            cur_tx <= cur_tx + 1'b1;
          end
        end
      end
    end
  end

  AST_SPAN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (tile_last(req_x, req_w, TWL) - tile_first(req_x, TWL) < MAXT) &&
             (tile_last(req_y, req_h, THL) - tile_first(req_y, THL) < MAXT) &&
             (req_w != '0) && (req_h != '0));  // R1
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid &&
      $stable({mem_req_id, cur_frame, cur_tx, cur_ty}));  // R2
  AST_ONE_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count != $past(hit_count) |-> miss_count == $past(miss_count));  // R1
  AST_TAKE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !win_ready && !req_accept);  // R10

endmodule

// File: rtl/mcc_ref_cache.sv
module mcc_ref_cache #(
  parameter int FW   = 2,
  parameter int CW   = 8,
  parameter int SW   = 5,
  parameter int TW   = 4,
  parameter int TH   = 2,
  parameter int PW   = 8,
  parameter int SETS = 8,
  parameter int MAXT = 4,
  parameter int CNTW = 16,
  localparam int TWL   = $clog2(TW),
  localparam int THL   = $clog2(TH),
  localparam int TXW   = CW - TWL,
  localparam int TYW   = CW - THL,
  localparam int SIB   = $clog2(SETS),
  localparam int IDW   = SIB + 1,
  localparam int XB    = $clog2(MAXT),
  localparam int NPIX  = TW * TH,
  localparam int SLW   = $clog2(NPIX),
  localparam int LINEW = NPIX * PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [FW-1:0]    req_frame,
  input  logic [CW-1:0]    req_x,
  input  logic [CW-1:0]    req_y,
  input  logic [SW-1:0]    req_w,
  input  logic [SW-1:0]    req_h,
  output logic             req_accept,
  output logic             win_ready,
  input  logic             rd_valid,
  input  logic [CW-1:0]    rd_x,
  input  logic [CW-1:0]    rd_y,
  output logic             rd_data_valid,
  output logic [PW-1:0]    rd_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [IDW-1:0]   mem_req_id,
  output logic [FW-1:0]    mem_req_frame,
  output logic [TXW-1:0]   mem_req_tx,
  output logic [TYW-1:0]   mem_req_ty,
  input  logic             mem_rsp_valid,
  input  logic [IDW-1:0]   mem_rsp_id,
  input  logic [LINEW-1:0] mem_rsp_data,
  output logic [CNTW-1:0]  hit_count,
  output logic [CNTW-1:0]  miss_count
);

  // named internal events
  logic           a_hit, a_hit_way, a_victim_way;
  logic [SIB-1:0] a_set;
  logic           upd_en, upd_alloc, upd_way, pin_clear, pend_any;
  logic           b_hit;
  logic [IDW-1:0] b_id;
  logic [TXW-1:0] b_tx;
  logic [TYW-1:0] b_ty;
  logic [SLW-1:0] b_slot;
  logic           rd_fire;

  assign b_tx    = TXW'(mcc_pkg::tile_first(rd_x, TWL));
  assign b_ty    = TYW'(mcc_pkg::tile_first(rd_y, THL));
  assign b_slot  = SLW'(mcc_pkg::byte_slot(rd_x, rd_y, TWL, THL));
  assign rd_fire = rd_valid && win_ready && b_hit;

  mcc_walker #(
    .CW(CW), .SW(SW), .FW(FW), .TWL(TWL), .THL(THL),
    .MAXT(MAXT), .CNTW(CNTW), .SIB(SIB)
  ) u_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_frame(req_frame), .req_x(req_x), .req_y(req_y),
    .req_w(req_w), .req_h(req_h), .req_accept(req_accept), .win_ready(win_ready),
    .cur_frame(mem_req_frame), .cur_tx(mem_req_tx), .cur_ty(mem_req_ty),
    .a_hit(a_hit), .a_hit_way(a_hit_way), .a_victim_way(a_victim_way), .a_set(a_set),
    .pend_any(pend_any), .upd_en(upd_en), .upd_alloc(upd_alloc), .upd_way(upd_way),
    .pin_clear(pin_clear), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_id(mem_req_id), .hit_count(hit_count), .miss_count(miss_count)
  );

  mcc_tags #(
    .FW(FW), .TXW(TXW), .TYW(TYW), .SETS(SETS), .XB(XB)
  ) u_tags (
    .clk(clk), .rst_n(rst_n),
    .a_frame(mem_req_frame), .a_tx(mem_req_tx), .a_ty(mem_req_ty),
    .a_hit(a_hit), .a_hit_way(a_hit_way), .a_victim_way(a_victim_way), .a_set(a_set),
    .upd_en(upd_en), .upd_alloc(upd_alloc), .upd_way(upd_way), .pin_clear(pin_clear),
    .rsp_en(mem_rsp_valid), .rsp_id(mem_rsp_id),
    .b_frame(mem_req_frame), .b_tx(b_tx), .b_ty(b_ty), .b_hit(b_hit), .b_id(b_id),
    .pend_any(pend_any)
  );

  mcc_lines #(
    .LINES(SETS * 2), .PW(PW), .TW(TW), .TH(TH)
  ) u_lines (
    .clk(clk), .rst_n(rst_n),
    .wr_en(mem_rsp_valid), .wr_id(mem_rsp_id), .wr_data(mem_rsp_data),
    .rd_en(rd_fire), .rd_id(b_id), .rd_slot(b_slot),
    .rd_valid_o(rd_data_valid), .rd_data_o(rd_data)
  );

  AST_READY_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |-> !pend_any);  // R3
  AST_NO_FETCH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |-> !mem_req_valid);  // R3
  AST_READ_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_valid |-> $past(win_ready));  // R4

endmodule

// File: tb/mcc_ref_cache_tb.sv
`timescale 1ns/1ps
module mcc_ref_cache_tb;
  localparam int TW = 4;
  localparam int TH = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, req_valid, req_accept, win_ready, rd_valid, rd_data_valid;
  logic [1:0]  req_frame, mem_req_frame;
  logic [7:0]  req_x, req_y, rd_x, rd_y, rd_data;
  logic [4:0]  req_w, req_h;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [3:0]  mem_req_id, mem_rsp_id;
  logic [5:0]  mem_req_tx;
  logic [6:0]  mem_req_ty;
  logic [63:0] mem_rsp_data;
  logic [15:0] hit_count, miss_count;

  mcc_ref_cache u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_frame(req_frame),
    .req_x(req_x), .req_y(req_y), .req_w(req_w), .req_h(req_h),
    .req_accept(req_accept), .win_ready(win_ready), .rd_valid(rd_valid),
    .rd_x(rd_x), .rd_y(rd_y), .rd_data_valid(rd_data_valid), .rd_data(rd_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_id(mem_req_id), .mem_req_frame(mem_req_frame),
    .mem_req_tx(mem_req_tx), .mem_req_ty(mem_req_ty),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_id(mem_rsp_id),
    .mem_rsp_data(mem_rsp_data), .hit_count(hit_count), .miss_count(miss_count)
  );

  int n_chk = 0, n_bad = 0;
  int outstanding = 0, reqs_total = 0;
  int win_f, win_tx0, win_tx1, win_ty0, win_ty1;
  bit ob_v [16];
  int ob_f [16], ob_tx [16], ob_ty [16], ob_wait [16];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pix(input int f, input int x, input int y);
    return 8'((f * 97 + x * 3 + y * 29 + ((x ^ y) & 15) * 5) & 255);
  endfunction

  function automatic logic [63:0] tile_line(input int f, input int tx, input int ty);
    logic [63:0] l;
    for (int k = 0; k < TW * TH; k++)
      l[8*k +: 8] = pix(f, tx * TW + k % TW, ty * TH + k / TW);
    return l;
  endfunction

  function automatic int tile_count(input int x, input int y, input int w, input int h);
    return ((x + w - 1) / TW - x / TW + 1) * ((y + h - 1) / TH - y / TH + 1);
  endfunction

  // bus responder: random ready, random delay, random order
  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_id = '0; mem_rsp_data = '0;
    for (int i = 0; i < 16; i++) ob_v[i] = 1'b0;
    @(posedge rst_n);
    forever begin
      bit picked;
      int start;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      picked = 1'b0;
      start = int'($urandom % 16);
      for (int i = 0; i < 16; i++) begin
        int j;
        j = (start + i) % 16;
        if (!picked && ob_v[j] && ob_wait[j] == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_id    = 4'(j);
          mem_rsp_data  = tile_line(ob_f[j], ob_tx[j], ob_ty[j]);
          ob_v[j] = 1'b0;
          outstanding--;
          picked = 1'b1;
        end
      end
      for (int i = 0; i < 16; i++) if (ob_v[i] && ob_wait[i] > 0) ob_wait[i]--;
      mem_req_ready = ($urandom % 4) != 0;
      if (mem_req_valid && mem_req_ready) begin
        int id;
        id = int'(mem_req_id);
        check(!ob_v[id], "R8 identifier not already outstanding", int'(ob_v[id]), 0);
        check(int'(mem_req_frame) == win_f && int'(mem_req_tx) >= win_tx0 &&
              int'(mem_req_tx) <= win_tx1 && int'(mem_req_ty) >= win_ty0 &&
              int'(mem_req_ty) <= win_ty1, "R2 request tile inside window",
              int'(mem_req_tx), win_tx0);
        ob_v[id] = 1'b1; ob_f[id] = int'(mem_req_frame);
        ob_tx[id] = int'(mem_req_tx); ob_ty[id] = int'(mem_req_ty);
        ob_wait[id] = 1 + int'($urandom % 24);
        outstanding++;
        reqs_total++;
      end
    end
  end

  task automatic run_window(input int f, input int x, input int y, input int w, input int h,
                            input int exp_miss, input string tag);
    int h0, m0, r0, tiles, dh, dm, cyc;
    tiles = tile_count(x, y, w, h);
    win_f = f; win_tx0 = x / TW; win_tx1 = (x + w - 1) / TW;
    win_ty0 = y / TH; win_ty1 = (y + h - 1) / TH;
    h0 = int'(hit_count); m0 = int'(miss_count); r0 = reqs_total;
    cyc = 0;
    while (!req_accept && cyc < 5000) begin @(negedge clk); cyc++; end
    req_valid = 1'b1; req_frame = 2'(f); req_x = 8'(x); req_y = 8'(y);
    req_w = 5'(w); req_h = 5'(h);
    @(negedge clk);
    req_valid = 1'b0;
    check(!win_ready && !req_accept, "R10 ready and accept drop after take",
          int'({win_ready, req_accept}), 0);
    cyc = 0;
    while (!win_ready && cyc < 5000) begin @(negedge clk); cyc++; end
    check(win_ready, "R3 window becomes ready", int'(win_ready), 1);
    check(outstanding == 0, "R3 no response outstanding at ready", outstanding, 0);
    dh = int'(hit_count) - h0; dm = int'(miss_count) - m0;
    check(dh + dm == tiles, "R1 one lookup per tile", dh + dm, tiles);
    check(dm == reqs_total - r0, "R2 one bus request per miss", reqs_total - r0, dm);
    if (exp_miss >= 0) check(dm == exp_miss, tag, dm, exp_miss);
    r0 = reqs_total;
    for (int yy = y; yy < y + h; yy++) begin
      for (int xx = x; xx < x + w; xx++) begin
        rd_valid = 1'b1; rd_x = 8'(xx); rd_y = 8'(yy);
        @(negedge clk);
        rd_valid = 1'b0;
        check(rd_data_valid && rd_data == pix(f, xx, yy), "R4 pixel read data",
              int'(rd_data), int'(pix(f, xx, yy)));
      end
    end
    check(reqs_total == r0, "R3 no bus request while ready", reqs_total - r0, 0);
  endtask

  initial begin
    int px, py;
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int px, py;
    void'($urandom(32'd7731));
    rst_n = 1'b0; req_valid = 1'b0; req_frame = '0; req_x = '0; req_y = '0;
    req_w = 5'd1; req_h = 5'd1; rd_valid = 1'b0; rd_x = '0; rd_y = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(hit_count == 0 && miss_count == 0, "R9 counters cleared",
          int'(hit_count) + int'(miss_count), 0);
    check(req_accept && !win_ready && !mem_req_valid, "R9 idle after reset",
          int'({req_accept, win_ready, mem_req_valid}), 4);

    // R6 replacement order in set 0: tiles (0,0), (4,0), (8,0) share it
    run_window(1, 0, 0, 1, 1, 1, "R6 cold tile misses");
    run_window(1, 16, 0, 1, 1, 1, "R6 second way filled");
    run_window(1, 0, 0, 1, 1, 0, "R6 resident tile hits");
    run_window(1, 32, 0, 1, 1, 1, "R6 third tile replaces LRU way");
    run_window(1, 0, 0, 1, 1, 0, "R6 recently used line survives");
    run_window(1, 16, 0, 1, 1, 1, "R6 evicted LRU line misses again");

    // R7 full 4x4-tile window: two tiles per set, both ways locked in turn
    run_window(0, 0, 0, 16, 8, 16, "R7 full window all misses");
    run_window(0, 0, 0, 16, 8, 0, "R5 repeated window all hits");
    run_window(0, 2, 1, 8, 4, 0, "R5 overlapping window served on chip");

    // constrained random overlapping windows
    px = 40; py = 40;
    for (int n = 0; n < 40; n++) begin
      int f, w, h;
      f  = int'($urandom % 2);
      px = px + int'($urandom % 13) - 6; if (px < 0) px = 0; if (px > 230) px = 230;
      py = py + int'($urandom % 9) - 4;  if (py < 0) py = 0; if (py > 230) py = 230;
      w  = 1 + int'($urandom % (16 - px % TW));
      h  = 1 + int'($urandom % (8 - py % TH));
      run_window(f, px, py, w, h, -1, "R1 random window");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule